// File: doc/BRIEF.md
# Selectable Waveform Streamer for a Four-Channel SPI DAC

This block lets an oscilloscope watch the internal state of a fixed-point motor model. It takes eleven signed fixed-point signals: three phase voltages, three back-EMFs, three phase currents, the torque and the speed. A 2-bit select input picks one display group of up to three signals. For each channel of that group in turn, the block converts the value to a 12-bit unsigned DAC code and packs it into a 32-bit command word. It then sends the word on a serial link: chip select goes low, one bit is presented for each rising clock edge, most significant bit first, and chip select goes high again. The block repeats this for channels 0, 1, 2, 0, ... without stopping.

The signal inputs are continuous levels with no handshake. The block samples them once, in the cycle a frame is loaded, so there is nothing to back-pressure. The serial side has no flow control either: the DAC must accept every frame. A new group select is only accepted at a frame boundary, and the new group always starts at channel 0.

Top module: `dac_wave_streamer`

## Requirements
- R1: While reset is asserted, `dac_cs_n` is 1, `dac_sck` is 0 and `dac_mosi` is 0.
- R2: Each frame holds `dac_cs_n` low for exactly 32 rising edges of `dac_sck`. The bits go out most significant first. `dac_mosi` changes only while `dac_sck` is low. Each `dac_sck` phase lasts HALF_CYC clocks.
- R3: Frame word layout: bits 31..24 are 0, bits 23..20 hold command 4'h3 (write and update), bits 19..16 hold the channel address, bits 15..4 hold the 12-bit code, and bits 3..0 are 0.
- R4: Conversion: shift the signed value arithmetically right by WIN_LSB, clamp it to -2048..2047, then add 2048. Zero gives 2048. Values above the range give 4095 and values below it give 0.
- R5: Group mapping by `set_sel`: 0 gives volt_a/b/c, 1 gives emf_a/b/c, 2 gives cur_a/b/c, 3 gives torque and speed on channels 0 and 1, with channel 2 held at code 2048.
- R6: Within a group, the channel address steps 0, 1, 2 and then wraps to 0, one step per frame.
- R7: `dac_cs_n` stays high for at least GAP_CYC clocks after reset and between frames (default 6, never fewer than 4).
- R8: A change of `set_sel` during a frame does not affect that frame. At the next frame load the new group is used and its first frame goes to channel 0.
- R9: `dac_sck` is low whenever `dac_cs_n` is high.
- R10: The code in a frame is taken from the input value in the cycle the frame is loaded. Changes to the input during the frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_sel | input | 2 | Display group select |
| volt_a | input | DATA_W | Phase A voltage, signed fixed point |
| volt_b | input | DATA_W | Phase B voltage |
| volt_c | input | DATA_W | Phase C voltage |
| emf_a | input | DATA_W | Phase A back-EMF |
| emf_b | input | DATA_W | Phase B back-EMF |
| emf_c | input | DATA_W | Phase C back-EMF |
| cur_a | input | DATA_W | Phase A current |
| cur_b | input | DATA_W | Phase B current |
| cur_c | input | DATA_W | Phase C current |
| torque | input | DATA_W | Electromagnetic torque |
| speed | input | DATA_W | Rotor speed |
| dac_cs_n | output | 1 | DAC chip select, active low |
| dac_sck | output | 1 | DAC serial clock |
| dac_mosi | output | 1 | DAC serial data |

## Verification
The assertions check the serial timing on every cycle:
- the clock stays idle while chip select is high,
- data holds steady through each high clock phase,
- every frame carries 32 clock rises,
- the chip-select gap is never shorter than GAP_CYC.

Word content is left to the bench's scenarios. That covers the command and padding fields, the window and saturation corners of the conversion, the group-to-channel mapping with its mid-scale filler, the channel order, the deferred group change with its restart at channel 0, and the freezing of a value at frame load. The bench's cycle model also compares all three pins every clock.

// File: rtl/dac_stream_pkg.sv
package dac_stream_pkg;
  localparam int FRAME_W    = 32;
  localparam int CODE_W     = 12;
  localparam int CH_PER_SET = 3;
  localparam int NUM_SRC    = 11;

  localparam logic [3:0]        CMD_WR_UPD = 4'h3;
  localparam logic [CODE_W-1:0] CODE_MID   = 12'h800;

  typedef enum logic {ST_GAP, ST_SHIFT} spi_state_e;

  typedef struct packed {
    logic [7:0]        lead;
    logic [3:0]        cmd;
    logic [3:0]        addr;
    logic [CODE_W-1:0] code;
    logic [3:0]        pad;
  } dac_frame_t;
endpackage

// File: rtl/dac_code_conv.sv
module dac_code_conv
  import dac_stream_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int WIN_LSB = 8
) (
  input  logic signed [DATA_W-1:0] din,
  output logic        [CODE_W-1:0] code
);
  localparam int HI_W = DATA_W - CODE_W + 1;

  logic signed [DATA_W-1:0] shifted;
  logic        [HI_W-1:0]   hi_bits;

  assign shifted = din >>> WIN_LSB;
  assign hi_bits = shifted[DATA_W-1:CODE_W-1];

  // in range when all bits above the code width copy the sign
  always_comb begin
    if (hi_bits == '0 || hi_bits == '1) begin
      code = {~shifted[CODE_W-1], shifted[CODE_W-2:0]};
    end else if (shifted[DATA_W-1]) begin
      code = '0;
    end else begin
      code = '1;
    end
  end
endmodule

// File: rtl/dac_set_mux.sv
module dac_set_mux
  import dac_stream_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic        [1:0]        set_idx,
  input  logic        [1:0]        ch_idx,
  input  logic signed [DATA_W-1:0] src [NUM_SRC],
  output logic signed [DATA_W-1:0] sample,
  output logic                     use_mid
);
  localparam int IDX_W = 4;

  logic [IDX_W-1:0] idx;
  logic [NUM_SRC-1:0] hit;

  assign idx = ({2'b00, set_idx} * 4'(CH_PER_SET)) + {2'b00, ch_idx};

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_hit
      assign hit[g] = (idx == IDX_W'(g));
    end
  endgenerate

  // index past the last source is the unused slot of the last group
  assign use_mid = (idx >= IDX_W'(NUM_SRC));

  always_comb begin
    sample = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hit[i]) sample = src[i];
    end
  end
endmodule

// File: rtl/dac_spi_shifter.sv
module dac_spi_shifter
  import dac_stream_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int GAP_CYC  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] word,
  output logic               load,
  output logic               cs_n,
  output logic               sck,
  output logic               mosi
);
  localparam int PH_W  = (2 * HALF_CYC > 2) ? $clog2(2 * HALF_CYC) : 1;
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(HALF_CYC - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * HALF_CYC - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  spi_state_e         state;
  logic [GAP_W-1:0]   gap_cnt;
  logic [PH_W-1:0]    ph_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;

  assign load = (state == ST_GAP) && (gap_cnt == GAP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_GAP;
      gap_cnt <= '0;
      ph_cnt  <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      cs_n    <= 1'b1;
      sck     <= 1'b0;
      mosi    <= 1'b0;
    end else begin
      case (state)
        ST_GAP: begin
          if (load) begin
            state   <= ST_SHIFT;
            gap_cnt <= '0;
            ph_cnt  <= '0;
            bit_cnt <= '0;
            cs_n    <= 1'b0;
            mosi    <= word[FRAME_W-1];
            shreg   <= {word[FRAME_W-2:0], 1'b0};
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (ph_cnt == PH_RISE) sck <= 1'b1;
          if (ph_cnt == PH_LAST) begin
            sck    <= 1'b0;
            ph_cnt <= '0;
            if (bit_cnt == BIT_LAST) begin
              cs_n  <= 1'b1;
              mosi  <= 1'b0;
              state <= ST_GAP;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              mosi    <= shreg[FRAME_W-1];
              shreg   <= {shreg[FRAME_W-2:0], 1'b0};
            end
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end
        default: state <= ST_GAP;
      endcase
    end
  end
endmodule

// File: rtl/dac_wave_streamer.sv
module dac_wave_streamer
  import dac_stream_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int WIN_LSB  = 8,
  parameter int HALF_CYC = 2,
  parameter int GAP_CYC  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               set_sel,
  input  logic signed [DATA_W-1:0] volt_a,
  input  logic signed [DATA_W-1:0] volt_b,
  input  logic signed [DATA_W-1:0] volt_c,
  input  logic signed [DATA_W-1:0] emf_a,
  input  logic signed [DATA_W-1:0] emf_b,
  input  logic signed [DATA_W-1:0] emf_c,
  input  logic signed [DATA_W-1:0] cur_a,
  input  logic signed [DATA_W-1:0] cur_b,
  input  logic signed [DATA_W-1:0] cur_c,
  input  logic signed [DATA_W-1:0] torque,
  input  logic signed [DATA_W-1:0] speed,
  output logic                     dac_cs_n,
  output logic                     dac_sck,
  output logic                     dac_mosi
);
  localparam logic [1:0] CH_LAST = 2'(CH_PER_SET - 1);

  logic signed [DATA_W-1:0] src [NUM_SRC];
  logic signed [DATA_W-1:0] sample;
  logic                     use_mid;
  logic [CODE_W-1:0]        raw_code;
  logic [1:0]               active_set_q;
  logic [1:0]               chan_q;
  logic [1:0]               eff_ch;
  logic                     set_change;
  logic                     load;
  dac_frame_t               frm;

  assign src[0]  = volt_a;
  assign src[1]  = volt_b;
  assign src[2]  = volt_c;
  assign src[3]  = emf_a;
  assign src[4]  = emf_b;
  assign src[5]  = emf_c;
  assign src[6]  = cur_a;
  assign src[7]  = cur_b;
  assign src[8]  = cur_c;
  assign src[9]  = torque;
  assign src[10] = speed;

  // a new group restarts at channel 0; the group itself is always set_sel
  assign set_change = (set_sel != active_set_q);
  assign eff_ch     = set_change ? 2'd0 : chan_q;

  dac_set_mux #(.DATA_W(DATA_W)) u_mux (
    .set_idx (set_sel),
    .ch_idx  (eff_ch),
    .src     (src),
    .sample  (sample),
    .use_mid (use_mid)
  );

  dac_code_conv #(.DATA_W(DATA_W), .WIN_LSB(WIN_LSB)) u_conv (
    .din  (sample),
    .code (raw_code)
  );

  always_comb begin
    frm.lead = '0;
    frm.cmd  = CMD_WR_UPD;
    frm.addr = {2'b00, eff_ch};
    frm.code = use_mid ? CODE_MID : raw_code;
    frm.pad  = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_set_q <= '0;
      chan_q       <= '0;
    end else if (load) begin
      active_set_q <= set_sel;
      chan_q       <= (eff_ch == CH_LAST) ? 2'd0 : eff_ch + 2'd1;
    end
  end

  dac_spi_shifter #(.HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)) u_spi (
    .clk   (clk),
    .rst_n (rst_n),
    .word  (frm),
    .load  (load),
    .cs_n  (dac_cs_n),
    .sck   (dac_sck),
    .mosi  (dac_mosi)
  );
endmodule

// File: rtl/dac_wave_streamer_chk.sv
module dac_wave_streamer_chk #(
  parameter int GAP_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic mosi
);
  localparam int GW = $clog2(GAP_CYC + 2);

  logic [GW-1:0] gap_cnt;
  logic [6:0]    rise_cnt;
  logic          sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      rise_cnt <= '0;
      sck_q    <= 1'b0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        if (gap_cnt < GW'(GAP_CYC)) gap_cnt <= gap_cnt + 1'b1;
        rise_cnt <= '0;
      end else begin
        gap_cnt <= '0;
        if (sck && !sck_q) rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  p_sck_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == 7'd32));

  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (gap_cnt >= GW'(GAP_CYC)));
endmodule

bind dac_wave_streamer dac_wave_streamer_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_n  (dac_cs_n),
  .sck   (dac_sck),
  .mosi  (dac_mosi)
);

// File: tb/dac_wave_streamer_bench.sv
module dac_wave_streamer_bench;
  localparam int DATA_W   = 24;
  localparam int WIN_LSB  = 8;
  localparam int HALF_CYC = 2;
  localparam int GAP_CYC  = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic [1:0] sel;
  logic signed [DATA_W-1:0] va, vb, vc, ea, eb, ec, ia, ib, ic, tq, sp;
  logic cs_n, sck, mosi;

  dac_wave_streamer #(.DATA_W(DATA_W), .WIN_LSB(WIN_LSB), .HALF_CYC(HALF_CYC),
                      .GAP_CYC(GAP_CYC)) u_dac_wave_streamer (
    .clk(clk), .rst_n(rst_n), .set_sel(sel),
    .volt_a(va), .volt_b(vb), .volt_c(vc),
    .emf_a(ea), .emf_b(eb), .emf_c(ec),
    .cur_a(ia), .cur_b(ib), .cur_c(ic),
    .torque(tq), .speed(sp),
    .dac_cs_n(cs_n), .dac_sck(sck), .dac_mosi(mosi)
  );

  integer checks = 0;
  integer errors = 0;
  bit     done   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [11:0] exp_code(input logic signed [DATA_W-1:0] v);
    integer s;
    s = v;
    s = s >>> WIN_LSB;
    if (s > 2047) return 12'd4095;
    if (s < -2048) return 12'd0;
    return 12'(s + 2048);
  endfunction

  function automatic logic signed [DATA_W-1:0] pick(input int k);
    case (k)
      0: return va;  1: return vb;  2: return vc;
      3: return ea;  4: return eb;  5: return ec;
      6: return ia;  7: return ib;  8: return ic;
      9: return tq;  default: return sp;
    endcase
  endfunction

  function automatic logic [31:0] exp_word(input int set, input int ch);
    logic [11:0] c;
    c = (set == 3 && ch == 2) ? 12'd2048 : exp_code(pick(set * 3 + ch));
    return {8'h00, 4'h3, 4'(ch), c, 4'h0};
  endfunction

  // cycle reference model
  int m_gap, m_pc, m_bit, m_ch, m_set;
  bit m_shift, m_cs, m_sck, m_mosi;
  logic [31:0] m_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gap = 0; m_pc = 0; m_bit = 0; m_ch = 0; m_set = 0;
      m_shift = 0; m_cs = 1; m_sck = 0; m_mosi = 0; m_word = '0;
    end else if (!m_shift) begin
      if (m_gap == GAP_CYC - 1) begin
        if (int'(sel) != m_set) begin
          m_set = int'(sel);
          m_ch = 0;
        end
        m_word = exp_word(m_set, m_ch);
        m_ch = (m_ch + 1) % 3;
        m_cs = 0; m_mosi = m_word[31];
        m_bit = 0; m_pc = 0; m_gap = 0; m_shift = 1;
      end else begin
        m_gap++;
      end
    end else begin
      if (m_pc == HALF_CYC - 1) m_sck = 1;
      if (m_pc == 2 * HALF_CYC - 1) begin
        m_sck = 0; m_pc = 0;
        if (m_bit == 31) begin
          m_cs = 1; m_mosi = 0; m_shift = 0; m_gap = 0;
        end else begin
          m_bit++;
          m_mosi = m_word[31 - m_bit];
        end
      end else begin
        m_pc++;
      end
    end
  end

  // per-cycle pin comparison and frame capture
  logic [31:0] frames[$];
  logic [31:0] cap;
  int nb;
  bit prev_sck, prev_cs;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cs_n == m_cs && sck == m_sck && mosi == m_mosi, "R2 R7 R9 cycle pins",
          {29'd0, cs_n, sck, mosi}, {29'd0, m_cs, m_sck, m_mosi});
      if (!cs_n && prev_cs) nb = 0;
      if (!cs_n && sck && !prev_sck) begin
        cap = {cap[30:0], mosi};
        nb++;
      end
      if (cs_n && !prev_cs) begin
        chk(nb == 32, "R2 bits per frame", nb, 32);
        frames.push_back(cap);
        nb = 0;
      end
    end
    prev_sck = sck;
    prev_cs  = cs_n;
  end

  task automatic next_frame(output logic [31:0] w);
    int n;
    n = frames.size();
    while (frames.size() == n) @(negedge clk);
    w = frames[$];
  endtask

  task automatic frame_is(input int addr, input logic [11:0] code, input string tag);
    logic [31:0] w;
    next_frame(w);
    chk(w[31:24] == 8'h00 && w[23:20] == 4'h3 && w[3:0] == 4'h0,
        "R3 fixed fields", w, {8'h00, 4'h3, w[19:4], 4'h0});
    chk(w[19:16] == 4'(addr), {tag, " addr R6"}, w[19:16], addr);
    chk(w[15:4] == code, {tag, " code"}, w[15:4], code);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic signed [DATA_W-1:0] old_ea;
    rst_n = 0; sel = 2'd0;
    va = 0; vb = 24'sh7FFFFF; vc = 24'sh800000;
    ea = 24'sh001000; eb = -24'sh002000; ec = 24'sh000080;
    ia = 24'sh07FF00; ib = -24'sh080000; ic = 24'sh080000;
    tq = 24'sh000A00; sp = 24'sh004321;
    repeat (5) @(negedge clk);
    chk(cs_n == 1 && sck == 0 && mosi == 0, "R1 reset pins",
        {29'd0, cs_n, sck, mosi}, 32'h4);
    rst_n = 1;

    // R4 corners: zero, positive and negative saturation
    frame_is(0, 12'd2048, "R4 zero midscale");
    frame_is(1, 12'd4095, "R4 positive saturate");
    frame_is(2, 12'd0,    "R4 negative saturate");

    // R4 window values; channel wraps (R6)
    va = 24'sh000100; vb = -24'sh000100; vc = 24'sh012300;
    frame_is(0, 12'd2049, "R4 plus one step");
    frame_is(1, 12'd2047, "R4 minus one step");
    frame_is(2, 12'd2339, "R4 window value");

    // R8: select changed mid-frame; current frame keeps group 0
    while (cs_n) @(negedge clk);
    repeat (20) @(negedge clk);
    sel = 2'd2;
    frame_is(0, 12'd2049, "R8 old group finishes");
    frame_is(0, exp_code(ia), "R8 new group at channel 0 R5");
    frame_is(1, 12'd0,    "R5 cur_b saturate low");
    frame_is(2, 12'd4095, "R5 cur_c saturate high");

    // R5 group 3 with midscale filler on channel 2
    sel = 2'd3;
    frame_is(0, exp_code(tq), "R5 torque");
    frame_is(1, exp_code(sp), "R5 speed");
    frame_is(2, 12'd2048, "R5 unused channel midscale");
    frame_is(0, exp_code(tq), "R6 wrap torque");

    // R8 restart at channel 0 even though channel 1 is next
    sel = 2'd1;
    frame_is(0, exp_code(ea), "R8 restart channel 0 R5");
    frame_is(1, exp_code(eb), "R5 emf_b");
    frame_is(2, exp_code(ec), "R5 emf_c");

    // R10: input change during a frame does not reach that frame
    while (cs_n) @(negedge clk);
    repeat (10) @(negedge clk);
    old_ea = ea;
    ea = -24'sh000300;
    frame_is(0, exp_code(old_ea), "R10 frozen at load");
    frame_is(1, exp_code(eb), "R10 emf_b");
    frame_is(2, exp_code(ec), "R10 emf_c");
    frame_is(0, 12'd2045, "R10 new value next frame R4");

    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule